// File: doc/BRIEF.md
# Debug Test Access Port with Scan-Chain Selection

This block is the test access port of a processor debug unit. It runs the standard sixteen-state TAP controller on TCK and TMS. It holds a 5-bit instruction register and a 5-bit chain-select register, and it steers TDI and TDO through whichever internal debug chain is currently active. Downstream chain logic receives three things from it: the active chain number, the current instruction, and a single-cycle strobe that asks the core to execute when the TAP enters Run-Test/Idle.

A host first loads the select instruction and shifts a chain number into the select register. The number it shifts out during that scan is a fixed marker, which confirms that the link works. The new chain takes effect at Update-DR. The host then loads the internal-test or external-test instruction to move data through that chain. A dedicated instruction reaches the instruction chain (chain 4) without disturbing the stored selection. Each debug chain here is a stub shift register that keeps its contents between scans. IDCODE and BYPASS are also provided.

Top module: `dbg_tap_top`

## Requirements
- R1: While trstN is low, and in Test-Logic-Reset, the instruction register holds IDCODE (5'h1E) and the select register holds 0, so activeChain reads 0.
- R2: Five rising TCK edges with TMS high bring the TAP to Test-Logic-Reset from any state, which reloads IDCODE and clears the selection.
- R3: The instruction register is 5 bits and shifts LSB first. It captures 5'b00001. Codes: EXTEST 5'h00, SCAN_N 5'h02, INTEST 5'h0C, ITRSEL 5'h1D, IDCODE 5'h1E, BYPASS 5'h1F.
- R4: With SCAN_N in the IR, the data path is the 5-bit select register. It captures 5'b10000 in Capture-DR and shifts LSB first.
- R5: A chain number shifted into the select register changes activeChain only when the TAP passes Update-DR. It does not change in Shift-DR, Exit1-DR or the Update-DR state itself.
- R6: ITRSEL makes activeChain read 4 and routes data through chain 4. The stored select register keeps its value, and that value is seen again once another instruction is loaded.
- R7: execStrobe pulses for exactly one TCK cycle when Run-Test/Idle is entered with INTEST or EXTEST in the IR and activeChain equal to 4 or 5. Staying in Run-Test/Idle does not repeat it. No other instruction produces it.
- R8: idleEntry pulses for one cycle on every entry to Run-Test/Idle. With chain 0 selected, that entry gives no execStrobe.
- R9: IDCODE selects a 32-bit register that captures ID_VALUE and shifts LSB first.
- R10: BYPASS and every unassigned instruction code select a 1-bit register that captures 0. The output therefore lags TDI by one bit.
- R11: TDO changes on the falling edge of TCK. tdoEn is 1 only in Shift-IR and Shift-DR, and TDO is 0 while tdoEn is 0.
- R12: INTEST, EXTEST and ITRSEL shift the active chain's STUB_W-bit stub register, LSB first and without capture, so a later scan shifts out what the previous scan shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous TAP reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdoEn | output | 1 | High while TDO is driven (shift states) |
| activeChain | output | 5 | Chain number currently routed |
| curInstr | output | 5 | Instruction register contents |
| idleEntry | output | 1 | One-cycle pulse on entering Run-Test/Idle |
| execStrobe | output | 1 | One-cycle execute request to chains 4 and 5 |

## Verification
The hardest case to observe is the interval in which a new chain number has been shifted in but not yet applied. The bench stops a select-register scan in Exit1-DR and checks activeChain there. It then moves one state into Update-DR and checks again. Only after the step into Run-Test/Idle does it expect the new value. A second hard case is the stored selection that hides behind ITRSEL: the bench writes chain 4 through ITRSEL, loads a different instruction to expose the stored chain 5, and then reads the same stub back through chain 4 selected the normal way.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

  localparam int IR_W  = 5;
  localparam int SEL_W = 5;

  localparam logic [IR_W-1:0] INS_EXTEST = 5'h00;
  localparam logic [IR_W-1:0] INS_SCANN  = 5'h02;
  localparam logic [IR_W-1:0] INS_INTEST = 5'h0C;
  localparam logic [IR_W-1:0] INS_ITRSEL = 5'h1D;
  localparam logic [IR_W-1:0] INS_IDCODE = 5'h1E;
  localparam logic [IR_W-1:0] INS_BYPASS = 5'h1F;

  localparam logic [IR_W-1:0]  IR_CAPTURE  = 5'b00001;
  localparam logic [SEL_W-1:0] SEL_MARKER  = 5'b10000;
  localparam logic [SEL_W-1:0] CHAIN_INSTR = 5'd4;
  localparam logic [SEL_W-1:0] CHAIN_DATA  = 5'd5;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SELDR, ST_CAPDR, ST_SHDR, ST_EX1DR, ST_PSDR, ST_EX2DR,
    ST_UPDR, ST_SELIR, ST_CAPIR, ST_SHIR, ST_EX1IR, ST_PSIR, ST_EX2IR, ST_UPIR
  } tapState_e;

  typedef enum logic [1:0] { DP_SEL, DP_ID, DP_BYP, DP_CHAIN } drPath_e;

  typedef struct packed {
    logic tlr;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
    logic rtiEntry;
  } tapStrobe_t;

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import dbg_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapStrobe_t strb
);

  tapState_e state, nextState, lastState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_TLR:   nextState = tms ? ST_TLR   : ST_RTI;
      ST_RTI:   nextState = tms ? ST_SELDR : ST_RTI;
      ST_SELDR: nextState = tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: nextState = tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  nextState = tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: nextState = tms ? ST_UPDR  : ST_PSDR;
      ST_PSDR:  nextState = tms ? ST_EX2DR : ST_PSDR;
      ST_EX2DR: nextState = tms ? ST_UPDR  : ST_SHDR;
      ST_UPDR:  nextState = tms ? ST_SELDR : ST_RTI;
      ST_SELIR: nextState = tms ? ST_TLR   : ST_CAPIR;
      ST_CAPIR: nextState = tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  nextState = tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: nextState = tms ? ST_UPIR  : ST_PSIR;
      ST_PSIR:  nextState = tms ? ST_EX2IR : ST_PSIR;
      ST_EX2IR: nextState = tms ? ST_UPIR  : ST_SHIR;
      ST_UPIR:  nextState = tms ? ST_SELDR : ST_RTI;
      default:  nextState = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      state     <= ST_TLR;
      lastState <= ST_TLR;
    end else begin
      state     <= nextState;
      lastState <= state;
    end
  end

  always_comb begin
    strb.tlr       = (state == ST_TLR);
    strb.captureIr = (state == ST_CAPIR);
    strb.shiftIr   = (state == ST_SHIR);
    strb.updateIr  = (state == ST_UPIR);
    strb.captureDr = (state == ST_CAPDR);
    strb.shiftDr   = (state == ST_SHDR);
    strb.updateDr  = (state == ST_UPDR);
    strb.rtiEntry  = (state == ST_RTI) && (lastState != ST_RTI);
  end

  // R2: five TMS-high edges always land in Test-Logic-Reset
  a_r2_tms_reset: assert property (@(posedge tck) disable iff (!trstN)
    (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state == ST_TLR));

endmodule

// File: rtl/tap_dp.sv
module tap_dp
  import dbg_tap_pkg::*;
#(
  parameter int          NUM_CHAINS = 8,
  parameter int          STUB_W     = 8,
  parameter logic [31:0] ID_VALUE   = 32'h0A53_C0DF
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tdi,
  input  tapStrobe_t       strb,
  output logic             tdo,
  output logic             tdoEn,
  output logic [SEL_W-1:0] activeChain,
  output logic [IR_W-1:0]  curInstr,
  output logic             execStrobe
);

  localparam int CIDX_W = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1;

  logic [IR_W-1:0]  irShift, irReg;
  logic [SEL_W-1:0] selShift, selReg;
  logic [31:0]      idShift;
  logic             bypassBit;
  logic [STUB_W-1:0] stubReg [NUM_CHAINS];
  logic [NUM_CHAINS-1:0] stubLsb;
  logic             chainValid;
  logic [CIDX_W-1:0] chainIdx;
  drPath_e          drPath;
  logic             drOut;

  assign activeChain = (irReg == INS_ITRSEL) ? CHAIN_INSTR : selReg;
  assign curInstr    = irReg;
  assign chainValid  = (32'(activeChain) < NUM_CHAINS);
  assign chainIdx    = activeChain[CIDX_W-1:0];

  always_comb begin
    unique case (irReg)
      INS_SCANN:  drPath = DP_SEL;
      INS_IDCODE: drPath = DP_ID;
      INS_INTEST, INS_EXTEST, INS_ITRSEL:
                  drPath = chainValid ? DP_CHAIN : DP_BYP;
      default:    drPath = DP_BYP;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift   <= '0;
      irReg     <= INS_IDCODE;
      selShift  <= '0;
      selReg    <= '0;
      idShift   <= '0;
      bypassBit <= 1'b0;
    end else begin
      if (strb.tlr) begin
        irReg  <= INS_IDCODE;
        selReg <= '0;
      end
      if (strb.captureIr) irShift <= IR_CAPTURE;
      if (strb.shiftIr)   irShift <= {tdi, irShift[IR_W-1:1]};
      if (strb.updateIr)  irReg   <= irShift;
      if (strb.captureDr) begin
        if (drPath == DP_SEL) selShift  <= SEL_MARKER;
        if (drPath == DP_ID)  idShift   <= ID_VALUE;
        if (drPath == DP_BYP) bypassBit <= 1'b0;
      end
      if (strb.shiftDr) begin
        if (drPath == DP_SEL) selShift  <= {tdi, selShift[SEL_W-1:1]};
        if (drPath == DP_ID)  idShift   <= {tdi, idShift[31:1]};
        if (drPath == DP_BYP) bypassBit <= tdi;
      end
      if (strb.updateDr && drPath == DP_SEL) selReg <= selShift;
    end
  end

  for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_stub
    always_ff @(posedge tck or negedge trstN) begin
      if (!trstN)
        stubReg[g] <= '0;
      else if (strb.shiftDr && drPath == DP_CHAIN && 32'(chainIdx) == g)
        stubReg[g] <= {tdi, stubReg[g][STUB_W-1:1]};
    end
    assign stubLsb[g] = stubReg[g][0];
  end

  always_comb begin
    unique case (drPath)
      DP_SEL:   drOut = selShift[0];
      DP_ID:    drOut = idShift[0];
      DP_CHAIN: drOut = stubLsb[chainIdx];
      default:  drOut = bypassBit;
    endcase
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strb.shiftIr | strb.shiftDr;
      tdo   <= strb.shiftIr ? irShift[0] : (strb.shiftDr ? drOut : 1'b0);
    end
  end

  assign execStrobe = strb.rtiEntry
                    && (activeChain == CHAIN_INSTR || activeChain == CHAIN_DATA)
                    && (irReg == INS_INTEST || irReg == INS_EXTEST);

  // R5: the stored selection moves only through Update-DR or a TAP reset
  a_r5_sel_update_only: assert property (@(posedge tck) disable iff (!trstN)
    (!(strb.updateDr && drPath == DP_SEL) && !strb.tlr) |=> $stable(selReg));

  // R4: capture always presents the link marker
  a_r4_capture_marker: assert property (@(posedge tck) disable iff (!trstN)
    (strb.captureDr && drPath == DP_SEL) |=> (selShift == SEL_MARKER));

  // R7: the execute request never lasts two cycles
  a_r7_exec_once: assert property (@(posedge tck) disable iff (!trstN)
    execStrobe |=> !execStrobe);

  // R1: after a TAP reset cycle the IR holds IDCODE
  a_r1_reset_idcode: assert property (@(posedge tck) disable iff (!trstN)
    strb.tlr |=> (curInstr == INS_IDCODE && activeChain == '0));

endmodule

// File: rtl/dbg_tap_top.sv
module dbg_tap_top
  import dbg_tap_pkg::*;
#(
  parameter int          NUM_CHAINS = 8,
  parameter int          STUB_W     = 8,
  parameter logic [31:0] ID_VALUE   = 32'h0A53_C0DF
) (
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  input  logic       tdi,
  output logic       tdo,
  output logic       tdoEn,
  output logic [4:0] activeChain,
  output logic [4:0] curInstr,
  output logic       idleEntry,
  output logic       execStrobe
);

  tapStrobe_t strb;

  tap_ctrl u_ctrl (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .strb  (strb)
  );

  tap_dp #(
    .NUM_CHAINS (NUM_CHAINS),
    .STUB_W     (STUB_W),
    .ID_VALUE   (ID_VALUE)
  ) u_dp (
    .tck         (tck),
    .trstN       (trstN),
    .tdi         (tdi),
    .strb        (strb),
    .tdo         (tdo),
    .tdoEn       (tdoEn),
    .activeChain (activeChain),
    .curInstr    (curInstr),
    .execStrobe  (execStrobe)
  );

  assign idleEntry = strb.rtiEntry;

endmodule

// File: tb/dbg_tap_top_tb.sv
module dbg_tap_top_tb;

  localparam logic [31:0] IDV = 32'h0A53_C0DF;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdoEn, idleEntry, execStrobe;
  logic [4:0] activeChain, curInstr;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2 tck = ~tck;

  dbg_tap_top #(.NUM_CHAINS(8), .STUB_W(8), .ID_VALUE(IDV)) u_dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .activeChain(activeChain), .curInstr(curInstr),
    .idleEntry(idleEntry), .execStrobe(execStrobe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one TCK: sample TDO after the falling edge, then drive for the next rising edge
  task automatic step(input logic m, input logic d, output logic o, output logic en);
    @(negedge tck); #1;
    o = tdo; en = tdoEn;
    tms = m; tdi = d;
    @(posedge tck);
  endtask

  // full scan from Run-Test/Idle back to Run-Test/Idle
  task automatic scan(input bit isIr, input int n, input logic [31:0] din,
                      output logic [31:0] dout, output logic allEn);
    logic o, e;
    dout = '0; allEn = 1'b1;
    step(1, 0, o, e);
    if (isIr) step(1, 0, o, e);
    step(0, 0, o, e);
    step(0, 0, o, e);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o, e);
      dout[i] = o; allEn &= e;
    end
    step(1, 0, o, e);
    step(0, 0, o, e);
    #1;
  endtask

  task automatic t_reset();
    trstN = 1'b0; tms = 1'b1;
    repeat (3) @(posedge tck);
    #1;
    chk("R1 reset instr", curInstr, 5'h1E);
    chk("R1 reset chain", activeChain, 0);
    chk("R11 tdoEn off in reset", tdoEn, 0);
    @(negedge tck); trstN = 1'b1;
  endtask

  task automatic t_idcode();
    logic [31:0] d; logic en, o, e;
    step(0, 0, o, e);
    scan(0, 32, 32'h0, d, en);
    chk("R9 idcode value", d, IDV);
    chk("R11 tdoEn during shift", en, 1);
    step(0, 0, o, e);
    step(0, 0, o, e);
    chk("R11 tdoEn low in idle", e, 0);
    chk("R11 tdo low when not driven", o, 0);
  endtask

  task automatic t_sel_timing();
    logic [31:0] d; logic en, o, e;
    scan(1, 5, 32'h02, d, en);
    chk("R3 IR capture pattern", d[4:0], 5'b00001);
    chk("R3 SCAN_N loaded", curInstr, 5'h02);
    step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, (5'd4 >> i) & 1'b1, o, e);
      d[i] = o;
    end
    #1;
    chk("R4 marker captured", d[4:0], 5'h10);
    chk("R5 unchanged in Exit1-DR", activeChain, 0);
    step(1, 0, o, e); #1;
    chk("R5 unchanged in Update-DR", activeChain, 0);
    step(0, 0, o, e); #1;
    chk("R5 applied after Update-DR", activeChain, 4);
    scan(0, 5, 32'h05, d, en);
    chk("R4 marker on second select scan", d[4:0], 5'h10);
    chk("R5 chain 5 selected", activeChain, 5);
  endtask

  task automatic t_exec();
    logic [31:0] d; logic en, o, e;
    scan(1, 5, 32'h00, d, en);
    chk("R7 exec on entry, EXTEST chain 5", execStrobe, 1);
    chk("R8 idle entry pulse", idleEntry, 1);
    step(0, 0, o, e); #1;
    chk("R7 no repeat while idle", execStrobe, 0);
    chk("R8 no repeat idle pulse", idleEntry, 0);
    scan(0, 8, 32'hA5, d, en);
    chk("R7 exec after DR scan", execStrobe, 1);
    scan(0, 8, 32'h3C, d, en);
    chk("R12 chain 5 retains data", d[7:0], 8'hA5);
  endtask

  task automatic t_itrsel();
    logic [31:0] d; logic en;
    scan(1, 5, 32'h1D, d, en);
    chk("R6 ITRSEL routes chain 4", activeChain, 4);
    chk("R7 no exec for ITRSEL", execStrobe, 0);
    scan(0, 8, 32'h5A, d, en);
    chk("R12 chain 4 initial contents", d[7:0], 8'h00);
    scan(1, 5, 32'h02, d, en);
    chk("R6 stored select kept", activeChain, 5);
    scan(0, 5, 32'h04, d, en);
    scan(1, 5, 32'h0C, d, en);
    chk("R7 exec on INTEST chain 4", execStrobe, 1);
    scan(0, 8, 32'h00, d, en);
    chk("R6 same chain 4 data", d[7:0], 8'h5A);
  endtask

  task automatic t_neutral();
    logic [31:0] d; logic en;
    scan(1, 5, 32'h02, d, en);
    scan(0, 5, 32'h00, d, en);
    scan(1, 5, 32'h0C, d, en);
    chk("R8 idle entry with chain 0", idleEntry, 1);
    chk("R8 no exec with chain 0", execStrobe, 0);
  endtask

  task automatic t_bypass();
    logic [31:0] d; logic en;
    scan(1, 5, 32'h1F, d, en);
    scan(0, 8, 32'hB6, d, en);
    chk("R10 bypass delay", d[7:0], 8'h6C);
    scan(1, 5, 32'h07, d, en);
    scan(0, 8, 32'h93, d, en);
    chk("R10 unassigned code bypass", d[7:0], 8'h26);
  endtask

  task automatic t_tms_reset();
    logic [31:0] d; logic en, o, e;
    scan(1, 5, 32'h02, d, en);
    scan(0, 5, 32'h05, d, en);
    scan(1, 5, 32'h00, d, en);
    repeat (5) step(1, 0, o, e);
    #1;
    chk("R2 tms reset instr", curInstr, 5'h1E);
    chk("R2 tms reset chain", activeChain, 0);
    step(0, 0, o, e);
  endtask

  initial begin
    t_reset();
    t_idcode();
    t_sel_timing();
    t_exec();
    t_itrsel();
    t_neutral();
    t_bypass();
    t_tms_reset();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule